// File: doc/BRIEF.md
# Integer Execution Unit with Immediate Path

This block is the combinational integer execution unit of a small load/store RISC core. Each cycle it takes a first register operand, a second register operand, a 16-bit immediate field and a few control bits from decode. It returns one 32-bit result and an equality flag. The result feeds the register write-back path or the data-memory address. The equality flag feeds the branch logic.

The second operand is either the register value or the immediate. The immediate is sign-extended or zero-extended, as decode selects. The unit adds, subtracts, ANDs, ORs, does a signed less-than compare that yields 0 or 1, and places a constant in the upper half of the word. A load or store address is formed by an add with a sign-extended offset. A full 32-bit constant is built in two steps: an upper-half load, then an OR with a zero-extended low half. The unit holds no state, so the result follows the inputs in the same cycle.

Top module: `xu_alu`

## Requirements
- R1: With `op_sel` = 0 (add), `result` is `opnd_a` plus the second operand, modulo 2^32.
- R2: With `op_sel` = 1 (subtract), `result` is `opnd_a` minus the second operand, modulo 2^32.
- R3: With `op_sel` = 4 (set-less-than), `result` is 1 when `opnd_a` is below the second operand as signed two's-complement numbers, and 0 otherwise. Bits 31:1 are always zero.
- R4: With `op_sel` = 2, `result` is the bitwise AND of `opnd_a` and the second operand. With `op_sel` = 3, it is the bitwise OR.
- R5: With `op_sel` = 5 (upper constant), `result` bits 31:16 equal `imm` and bits 15:0 are zero. `opnd_a`, `opnd_b`, `use_imm` and `imm_sext` have no effect on it.
- R6: When `use_imm` = 1, the second operand is the extended immediate and `opnd_b` has no effect on `result`. When `use_imm` = 0, the second operand is `opnd_b` and `imm` has no effect on `result` (except in the upper-constant operation).
- R7: When `imm_sext` = 1, the extended immediate copies `imm` bit 15 into bits 31:16. When `imm_sext` = 0, bits 31:16 are zero. Bits 15:0 always equal `imm`.
- R8: `equal` is 1 exactly when `opnd_a` equals `opnd_b`, whatever the values of `op_sel`, `use_imm` and `imm`.
- R9: The unused `op_sel` codes 6 and 7 give a `result` of zero.
- R10: An add with `use_imm` = 1 and `imm_sext` = 1 gives the byte address base + offset. A negative offset (imm bit 15 set) lowers the address, with wrap-around at zero.
- R11: An upper-constant operation with immediate H, followed by an OR with `use_imm` = 1, `imm_sext` = 0 and immediate L applied to that result, gives the 32-bit value {H, L}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First register operand (base register for address forming) |
| opnd_b | input | 32 | Second register operand |
| imm | input | 16 | Immediate field from the instruction |
| use_imm | input | 1 | 1 selects the extended immediate as the second operand |
| imm_sext | input | 1 | 1 sign-extends the immediate, 0 zero-extends it |
| op_sel | input | 3 | Operation: 0 add, 1 subtract, 2 AND, 3 OR, 4 set-less-than, 5 upper constant |
| result | output | 32 | Operation result |
| equal | output | 1 | 1 when opnd_a equals opnd_b |

## Verification
The assertions are immediate checks evaluated as the combinational logic settles. They assume the inputs are two-valued and that the inputs stay steady between the drive and the sample points. The bench changes inputs only on the falling clock edge and compares at the next rising edge, so every check sees settled values. The assertions also assume that `op_sel` may take any 3-bit code. The stimulus therefore includes the two unused codes, along with operands that have both sign bits set, equal operands, and immediates at the sign boundary.

// File: rtl/xu_pkg.sv
// Package: shared operation codes for the integer execution unit.
// Assumes a 3-bit operation select coming from the decoder.
package xu_pkg;
    typedef enum logic [2:0] {
        XU_ADD = 3'd0,
        XU_SUB = 3'd1,
        XU_AND = 3'd2,
        XU_OR  = 3'd3,
        XU_SLT = 3'd4,
        XU_LUI = 3'd5
    } xu_op_e;
endpackage

// File: rtl/xu_imm_ext.sv
// Module: widens the instruction immediate to the data width.
// Sign or zero fill is chosen per instruction by the sext input.
// Assumes DATA_W > IMM_W.
module xu_imm_ext #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [IMM_W-1:0]  imm,
    input  logic              sext,
    output logic [DATA_W-1:0] ext_val
);
    localparam int PAD_W = DATA_W - IMM_W;

    logic fill_bit;

    // Purpose: pick the fill bit and form the widened immediate.
    always_comb begin
        fill_bit = sext & imm[IMM_W-1];
        ext_val  = {{PAD_W{fill_bit}}, imm};
    end

    // Purpose: guard the extension rule against the raw inputs.
    always_comb begin
        // R7
        ext_low_chk: assert (ext_val[IMM_W-1:0] == imm);
        // R7
        ext_high_chk: assert (ext_val[DATA_W-1:IMM_W] ==
                              ((sext && imm[IMM_W-1]) ? {PAD_W{1'b1}} : {PAD_W{1'b0}}));
    end
endmodule

// File: rtl/xu_addsub.sv
// Module: shared adder for add, subtract and the signed less-than compare.
// The compare uses the subtract result. The caller asserts sub for compares.
module xu_addsub #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    output logic [DATA_W-1:0] sum,
    output logic              less
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] b_term;

    // Purpose: add a to b, or to the two's complement of b when sub is set.
    always_comb begin
        b_term = sub ? ~b : b;
        sum    = a + b_term + {{(DATA_W-1){1'b0}}, sub};
    end

    // Purpose: signed compare from the sign bits and the difference sign.
    always_comb begin
        less = (a[MSB] != b[MSB]) ? a[MSB] : sum[MSB];
    end

    // Purpose: guard adder and compare against plain arithmetic.
    always_comb begin
        // R1
        add_inv_chk: assert (sub || ((sum - b) == a));
        // R2
        sub_inv_chk: assert (!sub || ((sum + b) == a));
        // R3
        slt_sign_chk: assert (!sub || (less == ($signed(a) < $signed(b))));
    end
endmodule

// File: rtl/xu_bitwise.sv
// Module: bitwise AND/OR of the operands and the upper-half constant.
// Assumes DATA_W > IMM_W. The constant takes the top IMM_W bits.
module xu_bitwise #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] and_v,
    output logic [DATA_W-1:0] or_v,
    output logic [DATA_W-1:0] upper_v
);
    localparam int PAD_W = DATA_W - IMM_W;

    // Purpose: per-bit logic, with generate because the slice repeats.
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        always_comb begin
            and_v[i] = a[i] & b[i];
            or_v[i]  = a[i] | b[i];
        end
    end

    // Purpose: place the immediate in the high half and clear the low half.
    always_comb begin
        upper_v = {imm, {PAD_W{1'b0}}};
    end

    // Purpose: guard the upper-constant layout.
    always_comb begin
        // R5
        upper_low_chk: assert (upper_v[PAD_W-1:0] == '0);
        // R5
        upper_high_chk: assert (upper_v[DATA_W-1:PAD_W] == imm);
    end
endmodule

// File: rtl/xu_alu.sv
// Module: combinational integer execution unit (top).
// Selects the second operand, runs the arithmetic and logic units and
// muxes the result. It also drives the register-equality flag for branches.
// Assumes the inputs come from decode already aligned to this cycle.
module xu_alu #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [IMM_W-1:0]  imm,
    input  logic              use_imm,
    input  logic              imm_sext,
    input  logic [2:0]        op_sel,
    output logic [DATA_W-1:0] result,
    output logic              equal
);
    import xu_pkg::*;

    xu_op_e            op;
    logic [DATA_W-1:0] imm_wide;
    logic [DATA_W-1:0] b_eff;
    logic              do_sub;
    logic [DATA_W-1:0] arith_v;
    logic              lt_v;
    logic [DATA_W-1:0] and_v;
    logic [DATA_W-1:0] or_v;
    logic [DATA_W-1:0] upper_v;

    // Purpose: decode the select and choose the second operand.
    always_comb begin
        op     = xu_op_e'(op_sel);
        b_eff  = use_imm ? imm_wide : opnd_b;
        do_sub = (op == XU_SUB) || (op == XU_SLT);
    end

    xu_imm_ext #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_ext (
        .imm     (imm),
        .sext    (imm_sext),
        .ext_val (imm_wide)
    );

    xu_addsub #(.DATA_W(DATA_W)) u_arith (
        .a    (opnd_a),
        .b    (b_eff),
        .sub  (do_sub),
        .sum  (arith_v),
        .less (lt_v)
    );

    xu_bitwise #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_logic (
        .a       (opnd_a),
        .b       (b_eff),
        .imm     (imm),
        .and_v   (and_v),
        .or_v    (or_v),
        .upper_v (upper_v)
    );

    // Purpose: select the result for the current operation.
    always_comb begin
        unique case (op)
            XU_ADD, XU_SUB: result = arith_v;
            XU_AND:         result = and_v;
            XU_OR:          result = or_v;
            XU_SLT:         result = {{(DATA_W-1){1'b0}}, lt_v};
            XU_LUI:         result = upper_v;
            default:        result = '0;
        endcase
    end

    // Purpose: register-equality flag for the branch unit.
    always_comb begin
        equal = ~|(opnd_a ^ opnd_b);
    end

    // Purpose: guard the result mux and the flag at the unit boundary.
    always_comb begin
        // R3
        slt_width_chk: assert (op_sel != 3'd4 || result[DATA_W-1:1] == '0);
        // R9
        unused_zero_chk: assert (op_sel < 3'd6 || result == '0);
        // R8
        equal_flag_chk: assert (equal == (opnd_a == opnd_b));
        // R6
        imm_low_chk: assert (!use_imm || op_sel != 3'd3 || result[IMM_W-1:0] == (opnd_a[IMM_W-1:0] | imm));
    end
endmodule

// File: tb/xu_alu_test.sv
module xu_alu_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [15:0] imm = '0;
    logic        use_imm = 1'b0;
    logic        imm_sext = 1'b0;
    logic [2:0]  op_sel = '0;
    logic [31:0] result;
    logic        equal;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    xu_alu uut (
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .imm      (imm),
        .use_imm  (use_imm),
        .imm_sext (imm_sext),
        .op_sel   (op_sel),
        .result   (result),
        .equal    (equal)
    );

    // Behavioural reference for the result.
    function automatic logic [31:0] model(input logic [2:0] op, input logic [31:0] a,
                                          input logic [31:0] b, input logic [15:0] im,
                                          input logic ui, input logic se);
        logic [31:0] bb;
        longint      sa;
        longint      sb;
        if (!ui)     bb = b;
        else if (se) bb = 32'($signed(im));
        else         bb = 32'(im);
        sa = longint'($signed(a));
        sb = longint'($signed(bb));
        case (op)
            3'd0: return 32'(longint'(a) + longint'(bb));
            3'd1: return 32'(longint'(a) - longint'(bb));
            3'd2: return a & bb;
            3'd3: return a | bb;
            3'd4: return (sa < sb) ? 32'd1 : 32'd0;
            3'd5: return 32'(im) * 32'd65536;
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive on the falling edge, compare at the next rising edge.
    task automatic run(input string req, input logic [2:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] im,
                       input logic ui, input logic se);
        @(negedge clk);
        op_sel = op; opnd_a = a; opnd_b = b; imm = im; use_imm = ui; imm_sext = se;
        @(posedge clk);
        #1;
        check(req, result, model(op, a, b, im, ui, se));
        check({req, " R8 flag"}, {31'd0, equal}, {31'd0, a == b});
    endtask

    initial begin
        logic [31:0] hi_res;
        repeat (2) @(posedge clk);
        #1;
        // Reset state: all inputs zero, add of zeros
        check("R1 reset result", result, 32'd0);
        check("R8 reset flag", {31'd0, equal}, 32'd1);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 add with wrap
        run("R1 add", 3'd0, 32'h0000_0005, 32'h0000_0007, 16'h0, 1'b0, 1'b0);
        run("R1 add wrap", 3'd0, 32'hFFFF_FFFF, 32'h0000_0002, 16'h0, 1'b0, 1'b0);
        // R2 sub
        run("R2 sub", 3'd1, 32'h0000_0010, 32'h0000_0003, 16'h0, 1'b0, 1'b0);
        run("R2 sub borrow", 3'd1, 32'h0000_0000, 32'h0000_0001, 16'h0, 1'b0, 1'b0);
        // R3 signed compare
        run("R3 slt neg<pos", 3'd4, 32'h8000_0000, 32'h0000_0001, 16'h0, 1'b0, 1'b0);
        run("R3 slt pos>neg", 3'd4, 32'h0000_0001, 32'hFFFF_FFFF, 16'h0, 1'b0, 1'b0);
        run("R3 slt equal", 3'd4, 32'h1234_5678, 32'h1234_5678, 16'h0, 1'b0, 1'b0);
        run("R3 slt imm", 3'd4, 32'hFFFF_FFFE, 32'h0, 16'hFFFF, 1'b1, 1'b1);
        // R4 logic
        run("R4 and", 3'd2, 32'hF0F0_FF00, 32'h3C3C_0FF0, 16'h0, 1'b0, 1'b0);
        run("R4 or", 3'd3, 32'hF0F0_0000, 32'h0000_0F0F, 16'h0, 1'b0, 1'b0);
        // R5 upper constant ignores other operands
        run("R5 lui", 3'd5, 32'hDEAD_BEEF, 32'h1111_1111, 16'hABCD, 1'b1, 1'b1);
        run("R5 lui ignore", 3'd5, 32'h0, 32'h0, 16'h8001, 1'b0, 1'b0);
        // R6 immediate selects, opnd_b ignored
        run("R6 imm sel", 3'd0, 32'h100, 32'hFFFF_0000, 16'h0010, 1'b1, 1'b0);
        run("R6 imm ignored", 3'd0, 32'h100, 32'h5, 16'h7777, 1'b0, 1'b1);
        // R7 extension
        run("R7 sext and", 3'd2, 32'hFFFF_FFFF, 32'h0, 16'h8000, 1'b1, 1'b1);
        run("R7 zext and", 3'd2, 32'hFFFF_FFFF, 32'h0, 16'h8000, 1'b1, 1'b0);
        // R8 equal regardless of op / immediate
        run("R8 equal imm", 3'd3, 32'hCAFE_0001, 32'hCAFE_0001, 16'h1234, 1'b1, 1'b0);
        // R9 unused codes
        run("R9 op6", 3'd6, 32'hFFFF_FFFF, 32'h1, 16'hFFFF, 1'b0, 1'b1);
        run("R9 op7", 3'd7, 32'h1234, 32'h1234, 16'h1, 1'b1, 1'b0);
        // R10 effective address
        run("R10 addr pos", 3'd0, 32'h0000_1000, 32'h0, 16'h0030, 1'b1, 1'b1);
        run("R10 addr neg", 3'd0, 32'h0000_1000, 32'h0, 16'hFFFC, 1'b1, 1'b1);
        run("R10 addr wrap", 3'd0, 32'h0000_0002, 32'h0, 16'hFFF0, 1'b1, 1'b1);

        // R11 two-step constant
        run("R11 step1", 3'd5, 32'h0, 32'h0, 16'hAAAA, 1'b0, 1'b0);
        hi_res = result;
        run("R11 step2", 3'd3, hi_res, 32'h0, 16'h5555, 1'b1, 1'b0);
        check("R11 constant", result, 32'hAAAA_5555);

        // Random sweep across all codes and controls
        for (int i = 0; i < 600; i++) begin
            logic [2:0]  op;
            logic [31:0] a;
            logic [31:0] b;
            op = 3'($urandom_range(0, 7));
            a  = $urandom;
            b  = (i % 9 == 0) ? a : $urandom;
            case (op)
                3'd0: run("R1 rand", op, a, b, 16'($urandom), 1'($urandom), 1'($urandom));
                3'd1: run("R2 rand", op, a, b, 16'($urandom), 1'($urandom), 1'($urandom));
                3'd4: run("R3 rand", op, a, b, 16'($urandom), 1'($urandom), 1'($urandom));
                3'd5: run("R5 rand", op, a, b, 16'($urandom), 1'($urandom), 1'($urandom));
                3'd2, 3'd3: run("R4 rand", op, a, b, 16'($urandom), 1'($urandom), 1'($urandom));
                default: run("R9 rand", op, a, b, 16'($urandom), 1'($urandom), 1'($urandom));
            endcase
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule